// File: doc/BRIEF.md
# SDRAM Bank-State Protocol Monitor

This block is a passive observer for a four-bank SDRAM command bus. On every rising clock edge it samples clock enable, chip select, the three strobes, the two bank-select bits, the A10 line and the three low address bits used as the burst-length key. It keeps one small state machine per bank, plus that bank's timing counters. When a command is illegal for the current bank state or too early for a timing rule, it latches an error code naming that rule. It exposes which banks currently hold an open row.

The block sits beside a memory controller in simulation and drives nothing on the bus. It does not check data, and it does not model power-down or self refresh. The first violation it sees stays latched until a synchronous clear. The commands that break a rule still update the bank model, so later checks reflect what the memory would do.

Each bank machine has three states:
- **IDLE** moves to **ACTIVE** on an activate to that bank.
- **ACTIVE** moves to **IDLE** on a precharge that selects the bank, either by bank address or by A10 high.
- **ACTIVE** moves to **AP_BURST** on a read or write with A10 high (auto precharge).
- **AP_BURST** moves to **IDLE** in three cases: its burst counter expires, a burst stop arrives, or a precharge selects the bank.

Every move into IDLE starts the bank's precharge-time counter.

Top module: `sdram_proto_mon`

## Requirements
- R1: An activate opens the bank whose index is 2·BA0 + BA1. The encodings are BA1:BA0 = 00 → 0, 10 → 1, 01 → 2, 11 → 3. bank_open bit i shows bank i, and it is set in the cycle after the activate edge.
- R2: A cycle with cs_n high or cke low is a no-operation, whatever the strobes carry. It causes no state change and no error.
- R3: A mode register set (strobes 000) or an auto refresh (001) while any bank is open latches code 1.
- R4: A command that is not a no-operation, issued fewer than T_MRD cycles after a mode register set, latches code 2. This check takes priority over all other checks.
- R5: A precharge (strobes 010) with A10 high closes all four banks, whatever the bank address. A single-bank precharge (A10 low) closes only the addressed bank.
- R6: An activate (011) to an open bank latches code 3. A read (101), write (100) or single-bank precharge to a bank in IDLE latches code 4.
- R7: An activate issued fewer than T_RRD cycles after the previous activate latches code 5.
- R8: A read or write with A10 high, issued in cycle t with burst length BL, keeps the bank open through cycle t+BL. Any read or write to that bank in cycles t+1 to t+BL latches code 6. The bank is IDLE from cycle t+BL+1.
- R9: An activate to a bank fewer than T_RP cycles after the bank returns to IDLE latches code 7. Returning to IDLE happens by precharge, by the end of an auto-precharge burst, or by burst stop.
- R10: A single-bank or all-bank precharge that comes fewer than BL+T_RDL−1 cycles after a write without auto precharge to an affected bank latches code 8.
- R11: A burst stop (110) ends every running auto-precharge burst in its own cycle, so an activate to that bank is legal T_RP cycles later.
- R12: A mode register set loads the burst length from key bits [2:0]: 000 → 1, 001 → 2, 010 → 4, 011 → 8, 111 → PAGE_LEN, any other value → 1. The reset value is 1.
- R13: err_code holds the first nonzero code, and err_flag is high exactly while err_code is nonzero. clr empties both at the next edge, and it wins over a violation in the same cycle.
- R14: After reset, err_flag, err_code and bank_open are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous clear of the latched error |
| cke | input | 1 | Clock enable; low masks the command |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank select bits |
| a10 | input | 1 | Auto-precharge / precharge-all line |
| mode_key | input | 3 | Address bits 2..0, burst-length key at mode register set |
| err_flag | output | 1 | High while an error is latched |
| err_code | output | 4 | Code of the first violation, 0 when none |
| bank_open | output | 4 | Per-bank open-row status |

## Verification
The bench builds the monitor with PAGE_LEN = 8 and leaves T_MRD = 2, T_RRD = 2, T_RP = 3 and T_RDL = 2. The short page lets the full-page key be swept cycle by cycle, like the four fixed burst lengths. For every burst key, the bench moves the gap between an auto-precharge read and the next activate or read across every offset up to BL+T_RP. It also moves the gap between a write and a precharge across the whole tRDL window. The activate, precharge and mode-register spacing windows are swept one cycle past their limits. At each step the bench works out the expected code and open-bank mask from the rules alone.

// File: rtl/sdrchk_pkg.sv
package sdrchk_pkg;

    typedef enum logic [2:0] {
        C_NOP, C_MRS, C_REF, C_ACT, C_RD, C_WR, C_BST, C_PRE
    } cmd_e;

    typedef enum logic [3:0] {
        E_NONE     = 4'd0,
        E_NOT_IDLE = 4'd1,
        E_MRD      = 4'd2,
        E_ACT_OPEN = 4'd3,
        E_IDLE_ACC = 4'd4,
        E_RRD      = 4'd5,
        E_AP_BUSY  = 4'd6,
        E_RP       = 4'd7,
        E_WR_PRE   = 4'd8
    } err_e;

    typedef enum logic [1:0] {
        BK_IDLE, BK_ACTIVE, BK_AP_BURST
    } bank_st_e;

    typedef struct packed {
        cmd_e       op;
        logic [1:0] bank;
        logic       a10;
    } cmd_s;

endpackage

// File: rtl/sdrchk_decode.sv
module sdrchk_decode
    import sdrchk_pkg::*;
(
    input  logic       cke,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic [1:0] ba,
    input  logic       a10,
    output cmd_s       cmd
);

    always_comb begin
        cmd.bank = {ba[0], ba[1]};
        cmd.a10  = a10;
        if (!cke || cs_n) begin
            cmd.op = C_NOP;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b000:  cmd.op = C_MRS;
                3'b001:  cmd.op = C_REF;
                3'b010:  cmd.op = C_PRE;
                3'b011:  cmd.op = C_ACT;
                3'b100:  cmd.op = C_WR;
                3'b101:  cmd.op = C_RD;
                3'b110:  cmd.op = C_BST;
                default: cmd.op = C_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdrchk_mode.sv
module sdrchk_mode #(
    parameter int PAGE_LEN = 256,
    parameter int CW       = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [2:0]    key,
    output logic [CW-1:0] bl
);

    function automatic logic [CW-1:0] len_of(input logic [2:0] k);
        unique case (k)
            3'b000:  return CW'(1);
            3'b001:  return CW'(2);
            3'b010:  return CW'(4);
            3'b011:  return CW'(8);
            3'b111:  return CW'(PAGE_LEN);
            default: return CW'(1);
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n)    bl <= CW'(1);
        else if (load) bl <= len_of(key);
    end

    AST_BL_EIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        load && key == 3'b011 |=> bl == CW'(8)); // R12

endmodule

// File: rtl/sdrchk_bank.sv
module sdrchk_bank
    import sdrchk_pkg::*;
#(
    parameter int IDX   = 0,
    parameter int T_RP  = 3,
    parameter int T_RDL = 2,
    parameter int CW    = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cmd_s          cmd,
    input  logic [CW-1:0] bl,
    output logic          is_open,
    output logic          in_ap,
    output logic          rp_busy,
    output logic          wr_busy
);

    bank_st_e      st, nxt;
    logic [CW-1:0] burst, burst_n;
    logic [CW-1:0] rp, rp_n;
    logic [CW-1:0] wr, wr_n;
    logic          sel, pre_me, col_me;

    assign sel    = (cmd.bank == 2'(IDX));
    assign pre_me = (cmd.op == C_PRE) && (cmd.a10 || sel);
    assign col_me = (cmd.op == C_RD || cmd.op == C_WR) && sel;

    always_comb begin
        nxt     = st;
        burst_n = burst;
        rp_n    = (rp != '0) ? rp - 1'b1 : '0;
        wr_n    = (wr != '0) ? wr - 1'b1 : '0;
        unique case (st)
            BK_IDLE: begin
                if (cmd.op == C_ACT && sel) nxt = BK_ACTIVE;
            end
            BK_ACTIVE: begin
                if (pre_me) begin
                    nxt  = BK_IDLE;
                    rp_n = CW'(T_RP - 1);
                end else if (col_me && cmd.a10) begin
                    nxt     = BK_AP_BURST;
                    burst_n = bl;
                end else if (col_me && cmd.op == C_WR) begin
                    wr_n = bl + CW'(T_RDL) - CW'(2);
                end
            end
            BK_AP_BURST: begin
                if (pre_me || cmd.op == C_BST || burst == CW'(1)) begin
                    nxt     = BK_IDLE;
                    rp_n    = CW'(T_RP - 1);
                    burst_n = '0;
                end else begin
                    burst_n = burst - 1'b1;
                end
            end
            default: nxt = BK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= BK_IDLE;
            burst <= '0;
            rp    <= '0;
            wr    <= '0;
        end else begin
            st    <= nxt;
            burst <= burst_n;
            rp    <= rp_n;
            wr    <= wr_n;
        end
    end

    always_comb begin
        is_open = (st != BK_IDLE);
        in_ap   = (st == BK_AP_BURST);
        rp_busy = (rp != '0);
        wr_busy = (wr != '0);
    end

    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        st == BK_IDLE && cmd.op == C_ACT && sel |=> st == BK_ACTIVE); // R1

    AST_PRE_ALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.op == C_PRE && cmd.a10 |=> st == BK_IDLE); // R5

    AST_BST_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        st == BK_AP_BURST && cmd.op == C_BST |=> st == BK_IDLE); // R11

    AST_AP_HOLDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        st == BK_ACTIVE && col_me && cmd.a10 |=> st == BK_AP_BURST); // R8

endmodule

// File: rtl/sdram_proto_mon.sv
module sdram_proto_mon
    import sdrchk_pkg::*;
#(
    parameter int T_MRD    = 2,
    parameter int T_RRD    = 2,
    parameter int T_RP     = 3,
    parameter int T_RDL    = 2,
    parameter int PAGE_LEN = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       cke,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic [1:0] ba,
    input  logic       a10,
    input  logic [2:0] mode_key,
    output logic       err_flag,
    output logic [3:0] err_code,
    output logic [3:0] bank_open
);

    localparam int NB = 4;
    localparam int CW = $clog2(PAGE_LEN + T_RDL + T_RP + 2);
    localparam int GM = (T_MRD > T_RRD) ? T_MRD : T_RRD;
    localparam int GW = $clog2(GM + 1);

    cmd_s          cmd;
    logic [CW-1:0] bl;
    logic [NB-1:0] open_v, ap_v, rp_v, wr_v;
    logic [GW-1:0] mrd_cnt, rrd_cnt;
    err_e          viol, err_q;

    sdrchk_decode u_dec (
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .a10(a10), .cmd(cmd)
    );

    sdrchk_mode #(.PAGE_LEN(PAGE_LEN), .CW(CW)) u_mode (
        .clk(clk), .rst_n(rst_n), .load(cmd.op == C_MRS),
        .key(mode_key), .bl(bl)
    );

    for (genvar i = 0; i < NB; i++) begin : g_bank
        sdrchk_bank #(.IDX(i), .T_RP(T_RP), .T_RDL(T_RDL), .CW(CW)) u_bank (
            .clk(clk), .rst_n(rst_n), .cmd(cmd), .bl(bl),
            .is_open(open_v[i]), .in_ap(ap_v[i]),
            .rp_busy(rp_v[i]), .wr_busy(wr_v[i])
        );
    end

    always_comb begin
        viol = E_NONE;
        if (cmd.op != C_NOP) begin
            if (mrd_cnt != '0) begin
                viol = E_MRD;
            end else begin
                unique case (cmd.op)
                    C_MRS, C_REF: begin
                        if (|open_v) viol = E_NOT_IDLE;
                    end
                    C_ACT: begin
                        if (open_v[cmd.bank])    viol = E_ACT_OPEN;
                        else if (rp_v[cmd.bank]) viol = E_RP;
                        else if (rrd_cnt != '0)  viol = E_RRD;
                    end
                    C_RD, C_WR: begin
                        if (ap_v[cmd.bank])         viol = E_AP_BUSY;
                        else if (!open_v[cmd.bank]) viol = E_IDLE_ACC;
                    end
                    C_PRE: begin
                        if (cmd.a10) begin
                            if (|wr_v) viol = E_WR_PRE;
                        end else if (!open_v[cmd.bank]) begin
                            viol = E_IDLE_ACC;
                        end else if (wr_v[cmd.bank]) begin
                            viol = E_WR_PRE;
                        end
                    end
                    default: viol = E_NONE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mrd_cnt  <= '0;
            rrd_cnt  <= '0;
            err_q    <= E_NONE;
            err_flag <= 1'b0;
        end else begin
            mrd_cnt <= (cmd.op == C_MRS) ? GW'(T_MRD - 1)
                     : (mrd_cnt != '0) ? mrd_cnt - 1'b1 : '0;
            rrd_cnt <= (cmd.op == C_ACT) ? GW'(T_RRD - 1)
                     : (rrd_cnt != '0) ? rrd_cnt - 1'b1 : '0;
            if (clr) begin
                err_q    <= E_NONE;
                err_flag <= 1'b0;
            end else if (err_q == E_NONE && viol != E_NONE) begin
                err_q    <= viol;
                err_flag <= 1'b1;
            end
        end
    end

    assign err_code  = err_q;
    assign bank_open = open_v;

    AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        err_q != E_NONE && !clr |=> $stable(err_code)); // R13

    AST_CLEAR_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> err_code == 4'd0 && !err_flag); // R13

    AST_FLAG_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag == (err_code != 4'd0)); // R13

    AST_NOP_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n && !clr && err_code == 4'd0 |=> err_code == 4'd0); // R2

    AST_MRS_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.op == C_MRS && |bank_open && mrd_cnt == '0 && err_code == 4'd0 && !clr
        |=> err_code == 4'd1); // R3

endmodule

// File: tb/tb_sdram_proto_mon.sv
module tb_sdram_proto_mon;

    localparam int PG    = 8;
    localparam int T_MRD = 2;
    localparam int T_RRD = 2;
    localparam int T_RP  = 3;
    localparam int T_RDL = 2;

    localparam logic [2:0] OP_MRS = 3'b000;
    localparam logic [2:0] OP_REF = 3'b001;
    localparam logic [2:0] OP_PRE = 3'b010;
    localparam logic [2:0] OP_ACT = 3'b011;
    localparam logic [2:0] OP_WR  = 3'b100;
    localparam logic [2:0] OP_RD  = 3'b101;
    localparam logic [2:0] OP_BST = 3'b110;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0, clr = 1'b0, cke = 1'b1, cs_n = 1'b1;
    logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
    logic [1:0] ba = 2'b00;
    logic [2:0] mode_key = 3'b000;
    logic       err_flag;
    logic [3:0] err_code, bank_open;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sdram_proto_mon #(.T_MRD(T_MRD), .T_RRD(T_RRD), .T_RP(T_RP),
                      .T_RDL(T_RDL), .PAGE_LEN(PG)) dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cke(cke), .cs_n(cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
        .mode_key(mode_key), .err_flag(err_flag), .err_code(err_code),
        .bank_open(bank_open)
    );

    function automatic int bl_of(input logic [2:0] k);
        case (k)
            3'b000:  return 1;
            3'b001:  return 2;
            3'b010:  return 4;
            3'b011:  return 8;
            3'b111:  return PG;
            default: return 1;
        endcase
    endfunction

    function automatic logic [2:0] key_at(input int i);
        case (i)
            0: return 3'b000;
            1: return 3'b001;
            2: return 3'b010;
            3: return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

    task automatic drive(input logic cs_v, input logic cke_v, input logic [2:0] op,
                         input int bank, input logic ap, input logic [2:0] key);
        cs_n = cs_v; cke = cke_v;
        {ras_n, cas_n, we_n} = op;
        ba = {bank[0], bank[1]};
        a10 = ap; mode_key = key;
        @(negedge clk);
        cs_n = 1'b1; cke = 1'b1;
    endtask

    task automatic issue(input logic [2:0] op, input int bank, input logic ap,
                         input logic [2:0] key);
        drive(1'b0, 1'b1, op, bank, ap, key);
    endtask

    task automatic nop(input int n);
        cs_n = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset;
        cs_n = 1'b1; clr = 1'b0; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic check(input string tag, input int exp_code, input logic [3:0] exp_open);
        n_chk++;
        if (err_code !== 4'(exp_code) || bank_open !== exp_open ||
            err_flag !== (exp_code != 0)) begin
            n_bad++;
            $display("FAIL %s: code=%0d open=%b flag=%b expected code=%0d open=%b flag=%0d",
                     tag, err_code, bank_open, err_flag, exp_code, exp_open, exp_code != 0);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        @(negedge clk);
        do_reset;
        check("R14 reset", 0, 4'b0000);

        // R1: sweep the raw bank-select bits
        for (int v = 0; v < 4; v++) begin
            do_reset;
            cs_n = 1'b0; {ras_n, cas_n, we_n} = OP_ACT; ba = 2'(v); a10 = 1'b0;
            @(negedge clk); cs_n = 1'b1;
            check("R1 activate decode", 0, 4'(1 << (2 * (v % 2) + v / 2)));
            nop(1);
            cs_n = 1'b0; {ras_n, cas_n, we_n} = OP_PRE; ba = 2'(v); a10 = 1'b0;
            @(negedge clk); cs_n = 1'b1;
            check("R5 single precharge", 0, 4'b0000);
        end

        // R2: masked commands
        do_reset;
        issue(OP_ACT, 0, 0, 0); nop(2);
        drive(1'b1, 1'b1, OP_MRS, 0, 0, 0);
        check("R2 cs_n high masks mode set", 0, 4'b0001);
        drive(1'b0, 1'b0, OP_ACT, 1, 0, 0);
        check("R2 cke low masks activate", 0, 4'b0001);

        // R3
        do_reset;
        issue(OP_ACT, 0, 0, 0); nop(2);
        issue(OP_MRS, 0, 0, 0);
        check("R3 mode set with open bank", 1, 4'b0001);
        do_reset;
        issue(OP_ACT, 2, 0, 0); nop(2);
        issue(OP_REF, 0, 0, 0);
        check("R3 refresh with open bank", 1, 4'b0100);

        // R4: gap after mode register set
        for (int g = 1; g <= T_MRD + 1; g++) begin
            do_reset;
            issue(OP_MRS, 0, 0, 0); nop(g - 1);
            issue(OP_REF, 0, 0, 0);
            check("R4 mode set spacing", (g < T_MRD) ? 2 : 0, 4'b0000);
        end

        // R5 / R6: precharge all, then idle precharge
        do_reset;
        for (int b = 0; b < 4; b++) begin
            issue(OP_ACT, b, 0, 0); nop(1);
        end
        check("R5 four banks open", 0, 4'b1111);
        issue(OP_PRE, 2, 1, 0);
        check("R5 precharge all ignores bank", 0, 4'b0000);
        nop(1);
        issue(OP_PRE, 1, 0, 0);
        check("R6 precharge idle bank", 4, 4'b0000);

        do_reset;
        issue(OP_ACT, 3, 0, 0); nop(2);
        issue(OP_ACT, 3, 0, 0);
        check("R6 activate open bank", 3, 4'b1000);
        do_reset;
        issue(OP_RD, 0, 0, 0);
        check("R6 read idle bank", 4, 4'b0000);
        do_reset;
        issue(OP_WR, 1, 0, 0);
        check("R6 write idle bank", 4, 4'b0000);

        // R7: activate-to-activate
        for (int g = 1; g <= T_RRD + 1; g++) begin
            do_reset;
            issue(OP_ACT, 0, 0, 0); nop(g - 1);
            issue(OP_ACT, 1, 0, 0);
            check("R7 activate spacing", (g < T_RRD) ? 5 : 0, 4'b0011);
        end

        // R9: precharge-to-activate
        for (int g = 1; g <= T_RP + 1; g++) begin
            do_reset;
            issue(OP_ACT, 0, 0, 0); nop(2);
            issue(OP_PRE, 0, 0, 0); nop(g - 1);
            issue(OP_ACT, 0, 0, 0);
            check("R9 precharge time", (g < T_RP) ? 7 : 0, 4'b0001);
        end

        // R8 / R9 / R12: auto-precharge bursts for every burst key
        for (int k = 0; k < 5; k++) begin
            int b;
            b = bl_of(key_at(k));
            for (int g = 1; g <= b + T_RP; g++) begin
                int e;
                do_reset;
                issue(OP_MRS, 0, 0, key_at(k)); nop(1);
                issue(OP_ACT, 0, 0, 0); nop(1);
                issue(OP_RD, 0, 1, 0); nop(g - 1);
                issue(OP_ACT, 0, 0, 0);
                e = (g <= b) ? 3 : (g < b + T_RP) ? 7 : 0;
                check("R12 R9 activate after auto-precharge burst", e,
                      (g == b) ? 4'b0000 : 4'b0001);
            end
            for (int g = 1; g <= b + 1; g++) begin
                do_reset;
                issue(OP_MRS, 0, 0, key_at(k)); nop(1);
                issue(OP_ACT, 0, 0, 0); nop(1);
                issue(OP_WR, 0, 1, 0); nop(g - 1);
                issue(OP_RD, 0, 0, 0);
                check("R8 column during auto-precharge burst", (g <= b) ? 6 : 4,
                      (g < b) ? 4'b0001 : 4'b0000);
            end
        end

        // R10: write-to-precharge window for every burst key
        for (int k = 0; k < 5; k++) begin
            int b;
            b = bl_of(key_at(k));
            for (int g = 1; g <= b + T_RDL; g++) begin
                do_reset;
                issue(OP_MRS, 0, 0, key_at(k)); nop(1);
                issue(OP_ACT, 0, 0, 0);
                issue(OP_WR, 0, 0, 0); nop(g - 1);
                issue(OP_PRE, 0, (g % 2) == 1, 0);
                check("R10 write recovery", (g < b + T_RDL - 1) ? 8 : 0, 4'b0000);
            end
        end

        // R11: burst stop ends auto-precharge burst
        for (int g = 1; g <= T_RP; g++) begin
            do_reset;
            issue(OP_MRS, 0, 0, 3'b011); nop(1);
            issue(OP_ACT, 0, 0, 0); nop(1);
            issue(OP_RD, 0, 1, 0); nop(1);
            issue(OP_BST, 0, 0, 0);
            check("R11 burst stop closes bank", 0, 4'b0000);
            nop(g - 1);
            issue(OP_ACT, 0, 0, 0);
            check("R11 activate after burst stop", (g < T_RP) ? 7 : 0, 4'b0001);
        end

        // R13: first error held, clear, clear wins
        do_reset;
        issue(OP_RD, 0, 0, 0);
        issue(OP_ACT, 0, 0, 0); nop(2);
        issue(OP_ACT, 0, 0, 0);
        check("R13 first code held", 4, 4'b0001);
        clr = 1'b1; nop(1); clr = 1'b0;
        check("R13 clear empties code", 0, 4'b0001);
        issue(OP_REF, 0, 0, 0);
        check("R13 new code after clear", 1, 4'b0001);
        clr = 1'b1; issue(OP_MRS, 0, 0, 0); clr = 1'b0;
        check("R13 clear beats violation", 0, 4'b0001);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule